// File: doc/BRIEF.md
# Transmit Completion Result Ring

This block keeps a circular store of sixteen transmit-result records that two parties share: a result producer that reports how each frame fared, and a host that reads those reports. A record carries the frame's tag, a status byte, the number of failed acknowledgements, the air time used and the delay in the medium. Two ownership flags mark whether a slot holds news for the host. The flags are kept as a head flag and a tail flag, and the two must always agree.

The producer presents records on a valid/ready port. Only a record whose report bit is set takes a slot. When a record is stored, its slot is handed to the host in the same clock edge, and an interrupt may be raised. The host reads any slot by index through a combinational read port. It pulses a clear strobe to return the slot it has finished with. The interrupt is a level. It can fire on every stored record, or once the number of unread slots reaches a programmable threshold.

Top module: `txc_result_ring`

## Requirements
- R1: The ring has 16 slots. The write index starts at 0 after reset and moves up by one for each stored record. After slot 15 it goes back to slot 0.
- R2: A record presented with the report bit at 0 is accepted with ready high, whatever the ring holds, and is then dropped. It takes no slot, leaves the write index where it was and raises no interrupt.
- R3: Storing a record sets both the head and tail flags of its slot to 1 at the same edge that stores all of its data fields. All of this shows on the host read port from the cycle after the accepting edge.
- R4: A slot whose two flags are both 0 belongs to the producer. After reset every slot is in this state, ready is high and the interrupt is low.
- R5: While the slot at the write index has either flag set, ready is low for records whose report bit is 1. The flagged slot keeps its contents. Writing resumes once the host has cleared that slot.
- R6: A clear strobe sets both flags of the slot at the host index to 0 at the next edge. A clear aimed at a slot that is already unflagged changes nothing, including the count of unread slots.
- R7: With the per-record mode input at 1, the interrupt is high in the cycle after every stored record.
- R8: With the per-record mode at 0, the interrupt rises at the edge where a stored record brings the count of unread slots up to the 4-bit threshold or higher. A threshold of 0 never raises the interrupt.
- R9: Once raised, the interrupt stays high until the clear that brings the unread count to zero. It falls in the cycle after that clear.
- R10: The tag, status, retry count, air time and delay fields are stored exactly as given. The status byte uses this encoding: 0 is success; bit 7 is a transfer fault; bit 6 means sending was disabled; bit 5 means the retry limit was reached; bit 4 is a lifetime expiry; bit 3 means no key was found; bit 2 is a cipher failure; bit 1 means the priority was not available.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| res_valid_i | input | 1 | Producer has a result record |
| res_ready_o | output | 1 | Block can take the record this cycle |
| res_report_i | input | 1 | Frame asked for a completion report |
| res_id_i | input | 8 | Frame tag |
| res_status_i | input | 8 | Outcome status byte |
| res_retries_i | input | 8 | Count of failed acknowledgements |
| res_airtime_i | input | 16 | Air time consumed |
| res_delay_i | input | 32 | Delay spent in the medium |
| irq_each_i | input | 1 | 1: interrupt on every stored record |
| agg_thresh_i | input | 4 | Unread-slot threshold, 0 turns it off |
| host_idx_i | input | 4 | Slot index used for host read and clear |
| host_clr_i | input | 1 | Clear both flags of the indexed slot |
| host_own_head_o | output | 1 | Head flag of the indexed slot |
| host_own_tail_o | output | 1 | Tail flag of the indexed slot |
| host_id_o | output | 8 | Tag of the indexed slot |
| host_status_o | output | 8 | Status of the indexed slot |
| host_retries_o | output | 8 | Retry count of the indexed slot |
| host_airtime_o | output | 16 | Air time of the indexed slot |
| host_delay_o | output | 32 | Delay of the indexed slot |
| irq_o | output | 1 | Level completion interrupt |

## Verification
Ready is combinational, so it is due in the same cycle as the record it answers. Stored data, both flags and the interrupt are due one edge after the accepting edge, and the effect of a clear is due one edge after the strobe. The bench drives every input on the falling edge and checks ready a moment later, before the rising edge. It checks everything else on the falling edge that follows the edge being tested, with one time unit added after steering the read index.

// File: rtl/txr_pkg.sv
package txr_pkg;
  localparam int TXR_ID_W    = 8;
  localparam int TXR_STAT_W  = 8;
  localparam int TXR_RETRY_W = 8;
  localparam int TXR_AIR_W   = 16;
  localparam int TXR_DLY_W   = 32;

  typedef struct packed {
    logic [TXR_ID_W-1:0]    id;
    logic [TXR_STAT_W-1:0]  status;
    logic [TXR_RETRY_W-1:0] retries;
    logic [TXR_AIR_W-1:0]   airtime;
    logic [TXR_DLY_W-1:0]   delay;
  } txr_rec_t;
endpackage

// File: rtl/txr_ring_store.sv
module txr_ring_store
  import txr_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  txr_rec_t         wr_rec_i,
  input  logic             clr_en_i,
  input  logic [IDX_W-1:0] host_idx_i,
  output txr_rec_t         rd_rec_o,
  output logic [DEPTH-1:0] own_head_o,
  output logic [DEPTH-1:0] own_tail_o
);
  logic [DEPTH-1:0] head_q, head_d;
  logic [DEPTH-1:0] tail_q, tail_d;
  txr_rec_t         slot_q [DEPTH];

  // flag next state: a store wins over a clear of the same slot
  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    if (clr_en_i) begin
      head_d[host_idx_i] = 1'b0;
      tail_d[host_idx_i] = 1'b0;
    end
    if (wr_en_i) begin
      head_d[wr_idx_i] = 1'b1;
      tail_d[wr_idx_i] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  // data slots carry no reset; each has its own write enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en_i && (wr_idx_i == IDX_W'(g));
    always_ff @(posedge clk_i) begin
      if (slot_we) begin
        slot_q[g] <= wr_rec_i;
      end
    end
  end

  assign rd_rec_o   = slot_q[host_idx_i];
  assign own_head_o = head_q;
  assign own_tail_o = tail_q;
endmodule

// File: rtl/txr_wr_ctrl.sv
module txr_wr_ctrl #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             report_i,
  input  logic             slot_busy_i,
  output logic             ready_o,
  output logic             wr_fire_o,
  output logic [IDX_W-1:0] wr_idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ready_o   = !report_i || !slot_busy_i;
    wr_fire_o = valid_i && report_i && !slot_busy_i;
    ptr_d     = ptr_q;
    if (wr_fire_o) begin
      ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  assign wr_idx_o = ptr_q;
endmodule

// File: rtl/txr_irq_ctrl.sv
module txr_irq_ctrl #(
  parameter int DEPTH = 16,
  parameter int THR_W = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_fire_i,
  input  logic             clr_hit_i,
  input  logic             each_i,
  input  logic [THR_W-1:0] thresh_i,
  output logic             irq_o,
  output logic [CNT_W-1:0] pend_o
);
  localparam int CMP_W = (CNT_W > THR_W) ? CNT_W : THR_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_q, irq_d;
  logic             thr_hit;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_fire_i && !clr_hit_i) begin
      cnt_d = cnt_q + 1'b1;
    end else if (!wr_fire_i && clr_hit_i) begin
      cnt_d = cnt_q - 1'b1;
    end
    thr_hit = (thresh_i != '0) &&
              (CMP_W'(cnt_d) >= CMP_W'(thresh_i));
    irq_d = irq_q;
    if (wr_fire_i && (each_i || thr_hit)) begin
      irq_d = 1'b1;
    end else if (cnt_d == '0) begin
      irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq_q <= irq_d;
    end
  end

  assign irq_o  = irq_q;
  assign pend_o = cnt_q;
endmodule

// File: rtl/txc_result_ring.sv
module txc_result_ring
  import txr_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int THR_W = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   res_valid_i,
  output logic                   res_ready_o,
  input  logic                   res_report_i,
  input  logic [TXR_ID_W-1:0]    res_id_i,
  input  logic [TXR_STAT_W-1:0]  res_status_i,
  input  logic [TXR_RETRY_W-1:0] res_retries_i,
  input  logic [TXR_AIR_W-1:0]   res_airtime_i,
  input  logic [TXR_DLY_W-1:0]   res_delay_i,
  input  logic                   irq_each_i,
  input  logic [THR_W-1:0]       agg_thresh_i,
  input  logic [IDX_W-1:0]       host_idx_i,
  input  logic                   host_clr_i,
  output logic                   host_own_head_o,
  output logic                   host_own_tail_o,
  output logic [TXR_ID_W-1:0]    host_id_o,
  output logic [TXR_STAT_W-1:0]  host_status_o,
  output logic [TXR_RETRY_W-1:0] host_retries_o,
  output logic [TXR_AIR_W-1:0]   host_airtime_o,
  output logic [TXR_DLY_W-1:0]   host_delay_o,
  output logic                   irq_o
);
  txr_rec_t         wr_rec;
  txr_rec_t         rd_rec;
  logic [DEPTH-1:0] own_head;
  logic [DEPTH-1:0] own_tail;
  logic [IDX_W-1:0] wr_idx;
  logic             wr_fire;
  logic             slot_busy;
  logic             clr_hit;
  logic [CNT_W-1:0] pend_cnt;

  always_comb begin
    wr_rec.id      = res_id_i;
    wr_rec.status  = res_status_i;
    wr_rec.retries = res_retries_i;
    wr_rec.airtime = res_airtime_i;
    wr_rec.delay   = res_delay_i;
  end

  assign slot_busy = own_head[wr_idx] || own_tail[wr_idx];
  assign clr_hit   = host_clr_i && (own_head[host_idx_i] || own_tail[host_idx_i]);

  txr_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (res_valid_i),
    .report_i    (res_report_i),
    .slot_busy_i (slot_busy),
    .ready_o     (res_ready_o),
    .wr_fire_o   (wr_fire),
    .wr_idx_o    (wr_idx)
  );

  txr_ring_store #(.DEPTH(DEPTH)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_fire),
    .wr_idx_i   (wr_idx),
    .wr_rec_i   (wr_rec),
    .clr_en_i   (host_clr_i),
    .host_idx_i (host_idx_i),
    .rd_rec_o   (rd_rec),
    .own_head_o (own_head),
    .own_tail_o (own_tail)
  );

  txr_irq_ctrl #(.DEPTH(DEPTH), .THR_W(THR_W)) u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_fire_i (wr_fire),
    .clr_hit_i (clr_hit),
    .each_i    (irq_each_i),
    .thresh_i  (agg_thresh_i),
    .irq_o     (irq_o),
    .pend_o    (pend_cnt)
  );

  assign host_own_head_o = own_head[host_idx_i];
  assign host_own_tail_o = own_tail[host_idx_i];
  assign host_id_o       = rd_rec.id;
  assign host_status_o   = rd_rec.status;
  assign host_retries_o  = rd_rec.retries;
  assign host_airtime_o  = rd_rec.airtime;
  assign host_delay_o    = rd_rec.delay;
endmodule

// File: rtl/txr_ring_chk.sv
module txr_ring_chk #(
  parameter int DEPTH = 16,
  parameter int THR_W = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             res_valid_i,
  input logic             res_ready_o,
  input logic             res_report_i,
  input logic             wr_fire,
  input logic [IDX_W-1:0] wr_idx,
  input logic [DEPTH-1:0] own_head,
  input logic [DEPTH-1:0] own_tail,
  input logic [CNT_W-1:0] pend_cnt,
  input logic             irq_o,
  input logic             irq_each_i,
  input logic [THR_W-1:0] agg_thresh_i
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

  a_r1_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire && (wr_idx == LAST) |=> wr_idx == '0);

  a_r1_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire && (wr_idx != LAST) |=> wr_idx == $past(wr_idx) + 1'b1);

  a_r2_skip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && !res_report_i |=> wr_idx == $past(wr_idx));

  a_r3_flag_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    own_head == own_tail);

  a_r5_no_overwrite: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && res_ready_o && res_report_i |-> !own_head[wr_idx] && !own_tail[wr_idx]);

  a_r6_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(own_head) == int'(pend_cnt));

  a_r7_each: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_fire && irq_each_i |=> irq_o);

  a_r8_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o && !irq_each_i && (agg_thresh_i == '0) |=> !irq_o);

  a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> pend_cnt == '0);
endmodule

bind txc_result_ring txr_ring_chk #(.DEPTH(DEPTH), .THR_W(THR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .res_valid_i  (res_valid_i),
  .res_ready_o  (res_ready_o),
  .res_report_i (res_report_i),
  .wr_fire      (wr_fire),
  .wr_idx       (wr_idx),
  .own_head     (own_head),
  .own_tail     (own_tail),
  .pend_cnt     (pend_cnt),
  .irq_o        (irq_o),
  .irq_each_i   (irq_each_i),
  .agg_thresh_i (agg_thresh_i)
);

// File: tb/txc_result_ring_test.sv
module txc_result_ring_test;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        res_valid_i, res_report_i, res_ready_o;
  logic [7:0]  res_id_i, res_status_i, res_retries_i;
  logic [15:0] res_airtime_i;
  logic [31:0] res_delay_i;
  logic        irq_each_i;
  logic [3:0]  agg_thresh_i;
  logic [3:0]  host_idx_i;
  logic        host_clr_i;
  logic        host_own_head_o, host_own_tail_o;
  logic [7:0]  host_id_o, host_status_o, host_retries_o;
  logic [15:0] host_airtime_o;
  logic [31:0] host_delay_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #4 clk_i = ~clk_i;

  txc_result_ring uut (.*);

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc == 20000) begin
      fails = fails + 1;
      $display("FAIL R5 watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] idx);
    host_idx_i = idx;
    #1;
  endtask

  task automatic push(input logic rep, input logic [7:0] id, input logic [7:0] st);
    int n;
    @(negedge clk_i);
    res_valid_i   = 1'b1;
    res_report_i  = rep;
    res_id_i      = id;
    res_status_i  = st;
    res_retries_i = id ^ 8'h5A;
    res_airtime_i = {id, st};
    res_delay_i   = {4{id}};
    #1;
    n = 0;
    while (!res_ready_o && n < 100) begin
      @(negedge clk_i);
      #1;
      n++;
    end
    @(posedge clk_i);
    @(negedge clk_i);
    res_valid_i  = 1'b0;
    res_report_i = 1'b0;
  endtask

  task automatic clear(input logic [3:0] idx);
    @(negedge clk_i);
    host_idx_i = idx;
    host_clr_i = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    host_clr_i = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    check("R4 ready after reset", res_ready_o, 1'b1);
    check("R4 irq after reset", irq_o, 1'b0);
    for (int i = 0; i < 16; i++) begin
      rd(i[3:0]);
      check("R4 flags clear after reset", {host_own_head_o, host_own_tail_o}, 2'b00);
    end
  endtask

  task automatic t_each();
    irq_each_i = 1'b1;
    agg_thresh_i = 4'd0;
    push(1'b1, 8'h11, 8'h80);
    rd(4'd0);
    check("R3 both flags set", {host_own_head_o, host_own_tail_o}, 2'b11);
    check("R10 id echoed", host_id_o, 8'h11);
    check("R10 status DMA bit kept", host_status_o, 8'h80);
    check("R10 retries", host_retries_o, 8'h4B);
    check("R10 airtime", host_airtime_o, 16'h1180);
    check("R10 delay", host_delay_o, 32'h11111111);
    check("R7 irq after store", irq_o, 1'b1);
    clear(4'd0);
    rd(4'd0);
    check("R6 flags cleared", {host_own_head_o, host_own_tail_o}, 2'b00);
    check("R9 irq drops when empty", irq_o, 1'b0);
    push(1'b1, 8'h12, 8'h00);
    rd(4'd1);
    check("R1 second slot used", host_id_o, 8'h12);
    check("R7 irq second record", irq_o, 1'b1);
    clear(4'd1);
    check("R9 irq drops again", irq_o, 1'b0);
  endtask

  task automatic t_skip();
    push(1'b0, 8'h33, 8'h20);
    rd(4'd2);
    check("R2 no irq for unreported", irq_o, 1'b0);
    check("R2 no slot for unreported", host_own_head_o, 1'b0);
    push(1'b1, 8'h22, 8'h10);
    rd(4'd2);
    check("R2 index unchanged by drop", host_id_o, 8'h22);
    check("R2 next store flagged", host_own_tail_o, 1'b1);
    clear(4'd2);
  endtask

  task automatic t_thresh();
    irq_each_i = 1'b0;
    agg_thresh_i = 4'd3;
    push(1'b1, 8'h31, 8'h40);
    push(1'b1, 8'h32, 8'h08);
    check("R8 below threshold", irq_o, 1'b0);
    push(1'b1, 8'h33, 8'h02);
    check("R8 threshold reached", irq_o, 1'b1);
    rd(4'd5);
    check("R10 status priority bit", host_status_o, 8'h02);
    clear(4'd10);
    rd(4'd3);
    check("R6 stray clear leaves slot", host_own_head_o, 1'b1);
    clear(4'd3);
    check("R9 irq held two pending", irq_o, 1'b1);
    clear(4'd4);
    check("R9 irq held one pending", irq_o, 1'b1);
    clear(4'd5);
    check("R9 irq falls at empty", irq_o, 1'b0);
  endtask

  task automatic t_thr_edge();
    agg_thresh_i = 4'd0;
    push(1'b1, 8'h51, 8'h00);
    check("R8 threshold zero disables", irq_o, 1'b0);
    agg_thresh_i = 4'd1;
    push(1'b1, 8'h52, 8'h00);
    check("R8 threshold one", irq_o, 1'b1);
    clear(4'd6);
    check("R9 irq held", irq_o, 1'b1);
    clear(4'd7);
    check("R9 irq cleared", irq_o, 1'b0);
    agg_thresh_i = 4'd0;
  endtask

  task automatic t_full();
    for (int k = 0; k < 16; k++) begin
      push(1'b1, 8'h60 + k[7:0], 8'h00);
    end
    check("R8 no irq when disabled", irq_o, 1'b0);
    @(negedge clk_i);
    res_valid_i = 1'b1;
    res_report_i = 1'b1;
    res_id_i = 8'hFF;
    #1;
    check("R5 ready low when full", res_ready_o, 1'b0);
    repeat (3) @(negedge clk_i);
    #1;
    check("R5 still stalled", res_ready_o, 1'b0);
    rd(4'd8);
    check("R5 slot not overwritten", host_id_o, 8'h60);
    res_report_i = 1'b0;
    #1;
    check("R2 unreported passes when full", res_ready_o, 1'b1);
    @(posedge clk_i);
    @(negedge clk_i);
    res_valid_i = 1'b0;
    clear(4'd8);
    check("R5 ready after clear", res_ready_o, 1'b1);
    push(1'b1, 8'hEE, 8'h00);
    rd(4'd8);
    check("R5 resumed into freed slot", host_id_o, 8'hEE);
    rd(4'd0);
    check("R1 wrap 15 to 0", host_id_o, 8'h68);
    rd(4'd7);
    check("R1 last of ring", host_id_o, 8'h6F);
    for (int i = 0; i < 16; i++) clear(i[3:0]);
    check("R4 all returned", res_ready_o, 1'b1);
  endtask

  initial begin
    rst_ni = 1'b0;
    res_valid_i = 1'b0; res_report_i = 1'b0;
    res_id_i = '0; res_status_i = '0; res_retries_i = '0;
    res_airtime_i = '0; res_delay_i = '0;
    irq_each_i = 1'b0; agg_thresh_i = '0;
    host_idx_i = '0; host_clr_i = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    #1;
    t_reset();
    t_each();
    t_skip();
    t_thresh();
    t_thr_edge();
    t_full();
    summary();
    $finish;
  end
endmodule